// File: doc/BRIEF.md
# Early Zero-Result Predictor

This block sits next to a fixed-point adder/subtractor and tells the condition-code logic whether the result will be zero. It does not wait for the adder's carries. It takes two operands and an operation select. Subtraction is performed as A plus the inverted B with a carry-in of one.

From the operands it forms per-bit propagate and kill terms. Each bit's propagate is compared against the kill of its lower neighbour, and the lowest bit's propagate is compared against the carry-in. This gives one indicator bit per position. Any set indicator means the result is non-zero. A balanced OR tree reduces the indicators to a single flag. Because no carry chain is involved, the logic depth grows only with the log of the width.

A parameter selects how additions are judged.
- In modular mode (the default), the result is the N-bit wrapped sum. A plus its two's complement negation therefore predicts zero.
- In magnitude mode, the carry-out of an addition is part of the result. A zero is then predicted only when both addends are zero.

In either mode, subtraction predicts zero exactly when the two operands are equal.

Top module: `early_zero_predictor`

## Requirements
- R1: With WRAP_ADD=1, zero_o is 1 exactly when (A + (sub_i ? ~B : B) + sub_i) mod 2^WIDTH equals 0, and 0 otherwise.
- R2: nonzero_o is always the bitwise inverse of zero_o.
- R3: With sub_i=1, zero_o is 1 exactly when a_i equals b_i, for both values of WRAP_ADD.
- R4: With sub_i=0 and both operands zero, zero_o is 1 for both values of WRAP_ADD.
- R5: With WRAP_ADD=1 and sub_i=0, a non-zero A added to 2^WIDTH - A predicts zero.
- R6: With sub_i=0, one operand zero and the other non-zero, zero_o is 0.
- R7: With sub_i=1, operands that differ in a single bit (including the least and the most significant bit) give zero_o=0.
- R8: The outputs are combinational: they follow a change of a_i, b_i or sub_i with no clock edge in between.
- R9: With WRAP_ADD=0 and sub_i=0, zero_o is 1 only when both operands are zero; a sum that wraps to zero in WIDTH bits gives zero_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (inverted internally for subtraction) |
| sub_i | input | 1 | 0 selects A+B, 1 selects A-B |
| zero_o | output | 1 | Predicted zero result |
| nonzero_o | output | 1 | Inverse of zero_o |

## Verification
The checker tests several properties whenever an input changes:
- the two outputs are complementary;
- subtraction flags zero exactly on equal operands;
- zero operands in addition give a zero flag;
- in each mode, the addition flag agrees with a plain sum of matching width.

Some behaviours can only be shown by the bench's scenarios, since they depend on choosing particular operand values:
- the wrap-around pair that separates the two addition modes;
- the one-bit differences at the edges of the word;
- the outputs settling without any clock edge.

// File: rtl/ezp_pkg.sv
package ezp_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        logic zero;
        logic nonzero;
    } flags_t;

endpackage

// File: rtl/ezp_term_gen.sv
// Per-bit propagate and kill terms of A and the effective B.
module ezp_term_gen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             invert_b,
    output logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] kill
);
    logic [WIDTH-1:0] b_eff;

    assign b_eff = invert_b ? ~b : b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign prop[i] = a[i] ^ b_eff[i];
        assign kill[i] = ~(a[i] | b_eff[i]);
    end
endmodule

// File: rtl/ezp_indicator.sv
// One indicator per position: set when that position cannot be zero
// given the carry it would have to receive from below.
module ezp_indicator #(
    parameter int WIDTH    = 32,
    parameter bit WRAP_ADD = 1'b1,
    localparam int NIND    = WIDTH + 1
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] kill,
    input  logic             carry_in,
    input  logic             is_add,
    output logic [NIND-1:0]  ind
);
    // the lowest position must see propagate equal to the carry-in
    assign ind[0] = prop[0] ^ carry_in;

    // higher positions: propagate must equal the carry implied by neighbour
    for (genvar i = 1; i < WIDTH; i++) begin : g_pos
        assign ind[i] = prop[i] ^ ~kill[i-1];
    end

    if (WRAP_ADD) begin : g_wrap
        assign ind[WIDTH] = 1'b0;
    end else begin : g_mag
        // carry-out of an addition is part of the result and must be zero
        assign ind[WIDTH] = is_add & ~kill[WIDTH-1];
    end
endmodule

// File: rtl/ezp_or_tree.sv
// Balanced OR reduction, heap-ordered node array.
module ezp_or_tree #(
    parameter int N = 33,
    localparam int LEVELS = (N > 1) ? $clog2(N) : 1,
    localparam int LEAVES = 1 << LEVELS,
    localparam int NODES  = 2 * LEAVES - 1
) (
    input  logic [N-1:0] vec,
    output logic         any
);
    logic [NODES-1:0] node;

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < N) begin : g_used
            assign node[LEAVES-1+k] = vec[k];
        end else begin : g_pad
            assign node[LEAVES-1+k] = 1'b0;
        end
    end

    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        assign node[k] = node[2*k+1] | node[2*k+2];
    end

    assign any = node[0];
endmodule

// File: rtl/early_zero_predictor.sv
module early_zero_predictor #(
    parameter int WIDTH    = 32,
    parameter bit WRAP_ADD = 1'b1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic             zero_o,
    output logic             nonzero_o
);
    import ezp_pkg::*;

    localparam int NIND = WIDTH + 1;

    op_e               op;
    logic [WIDTH-1:0]  prop;
    logic [WIDTH-1:0]  kill;
    logic [NIND-1:0]   ind;
    logic              any_set;
    flags_t            flags_d;

    assign op = op_e'(sub_i);

    ezp_term_gen #(.WIDTH(WIDTH)) u_terms (
        .a        (a_i),
        .b        (b_i),
        .invert_b (op == OP_SUB),
        .prop     (prop),
        .kill     (kill)
    );

    ezp_indicator #(.WIDTH(WIDTH), .WRAP_ADD(WRAP_ADD)) u_ind (
        .prop     (prop),
        .kill     (kill),
        .carry_in (op == OP_SUB),
        .is_add   (op == OP_ADD),
        .ind      (ind)
    );

    ezp_or_tree #(.N(NIND)) u_tree (
        .vec (ind),
        .any (any_set)
    );

    always_comb begin
        flags_d         = '0;
        flags_d.nonzero = any_set;
        flags_d.zero    = ~any_set;
    end

    assign zero_o    = flags_d.zero;
    assign nonzero_o = flags_d.nonzero;
endmodule

// File: rtl/ezp_checker.sv
module ezp_checker #(
    parameter int WIDTH    = 32,
    parameter bit WRAP_ADD = 1'b1
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             sub_i,
    input logic             zero_o,
    input logic             nonzero_o
);
    logic [WIDTH:0] full_sum;

    assign full_sum = {1'b0, a_i} + {1'b0, b_i};

    always_comb begin
        assert_outputs_inverse_R2: assert (zero_o != nonzero_o);

        if (sub_i) begin
            assert_sub_equal_R3: assert (zero_o == (a_i == b_i));
        end

        if (!sub_i && a_i == '0 && b_i == '0) begin
            assert_add_zero_ops_R4: assert (zero_o);
        end

        if (!sub_i && WRAP_ADD) begin
            assert_add_wrap_match_R1: assert (zero_o == (full_sum[WIDTH-1:0] == '0));
        end

        if (!sub_i && !WRAP_ADD) begin
            assert_add_magnitude_R9: assert (zero_o == (full_sum == '0));
        end
    end
endmodule

bind early_zero_predictor ezp_checker #(.WIDTH(WIDTH), .WRAP_ADD(WRAP_ADD)) chk_i (
    .a_i       (a_i),
    .b_i       (b_i),
    .sub_i     (sub_i),
    .zero_o    (zero_o),
    .nonzero_o (nonzero_o)
);

// File: tb/early_zero_predictor_tb.sv
module early_zero_predictor_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sub;
    logic         zero_w, nonzero_w;
    logic         zero_m, nonzero_m;
    int           checks = 0;
    int           fails  = 0;
    bit           done   = 1'b0;

    always #5 clk = ~clk;

    early_zero_predictor #(.WIDTH(W), .WRAP_ADD(1'b1)) dut_i (
        .a_i (a), .b_i (b), .sub_i (sub), .zero_o (zero_w), .nonzero_o (nonzero_w)
    );

    early_zero_predictor #(.WIDTH(W), .WRAP_ADD(1'b0)) dut_mag_i (
        .a_i (a), .b_i (b), .sub_i (sub), .zero_o (zero_m), .nonzero_o (nonzero_m)
    );

    function automatic logic [W:0] model_sum(logic [W-1:0] x, logic [W-1:0] y, logic s);
        return {1'b0, x} + {1'b0, (s ? ~y : y)} + {{W{1'b0}}, s};
    endfunction

    task automatic expect_bit(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s a=%h b=%h sub=%0b actual=%0b expected=%0b",
                     req, what, a, b, sub, got, exp);
        end
    endtask

    // drive after an edge, check at the falling edge
    task automatic apply(string req, logic [W-1:0] x, logic [W-1:0] y, logic s);
        logic [W:0] full;
        logic       exp_wrap, exp_mag;
        @(posedge clk);
        #1;
        a = x; b = y; sub = s;
        full     = model_sum(x, y, s);
        exp_wrap = (full[W-1:0] == '0);
        exp_mag  = s ? (x == y) : (full == '0);
        @(negedge clk);
        expect_bit(req, "wrap zero", zero_w, exp_wrap);
        expect_bit(req, "mag zero", zero_m, exp_mag);
        expect_bit("R2", "wrap inverse", nonzero_w, ~zero_w);
        expect_bit("R2", "mag inverse", nonzero_m, ~zero_m);
    endtask

    task automatic t_zero_operands;  // R4
        apply("R4", '0, '0, 1'b0);
    endtask

    task automatic t_equal_sub;      // R3
        apply("R3", '0, '0, 1'b1);
        apply("R3", '1, '1, 1'b1);
        apply("R3", 32'h8000_0000, 32'h8000_0000, 1'b1);
        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] v;
            v = $urandom();
            apply("R3", v, v, 1'b1);
        end
    endtask

    task automatic t_one_bit_diff;   // R7
        apply("R7", 32'h0000_0001, 32'h0000_0000, 1'b1);
        apply("R7", 32'h8000_0000, 32'h0000_0000, 1'b1);
        apply("R7", 32'h1234_5678, 32'h9234_5678, 1'b1);
        for (int i = 0; i < W; i++) begin
            logic [W-1:0] v;
            v = $urandom();
            apply("R7", v, v ^ (32'h1 << i), 1'b1);
        end
    endtask

    task automatic t_add_wrap;       // R5 and R9
        apply("R5", 32'h0000_0001, 32'hFFFF_FFFF, 1'b0);
        apply("R5", 32'h8000_0000, 32'h8000_0000, 1'b0);
        for (int i = 0; i < 16; i++) begin
            logic [W-1:0] v;
            v = $urandom() | 32'h1;
            apply("R9", v, (~v) + 32'h1, 1'b0);
        end
    endtask

    task automatic t_add_one_zero;   // R6
        apply("R6", 32'h0000_0000, 32'h0000_0001, 1'b0);
        apply("R6", 32'h8000_0000, 32'h0000_0000, 1'b0);
        apply("R6", 32'h0000_0000, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_random;         // R1
        for (int i = 0; i < 400; i++) begin
            apply("R1", $urandom(), $urandom(), 1'($urandom() & 1));
        end
    endtask

    task automatic t_comb_settle;    // R8: no clock edge between change and check
        @(negedge clk);
        a = 32'h55AA_1234; b = 32'h55AA_1234; sub = 1'b1;
        #1;
        expect_bit("R8", "settle zero", zero_w, 1'b1);
        a = 32'h55AA_1235;
        #1;
        expect_bit("R8", "settle nonzero", zero_w, 1'b0);
        sub = 1'b0; a = 32'h0; b = 32'h0;
        #1;
        expect_bit("R8", "settle add zero", zero_m, 1'b1);
    endtask

    initial begin
        a = '0; b = '0; sub = 1'b0;
        #2;
        expect_bit("R4", "initial wrap", zero_w, 1'b1);
        expect_bit("R4", "initial mag", zero_m, 1'b1);
        t_zero_operands();
        t_equal_sub();
        t_one_bit_diff();
        t_add_wrap();
        t_add_one_zero();
        t_random();
        t_comb_settle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule